// File: doc/BRIEF.md
# Learning MAC Lookup Stage

This block sits inline in a 256-bit packet stream and decides which output queues each Ethernet frame goes to. It extracts the destination and source addresses from the first beat of each frame. A small table built from registers and searched in parallel remembers which ingress port each source address was last seen on. The destination address is then looked up in that table. A known unicast destination sends the frame to the port stored for it. An unknown destination, or any group address, floods the frame to the physical ports.

The chosen output mask is written into a field of the TUSER side channel on the first beat of the frame. Every other bit of every beat passes through unchanged. Each beat is held for exactly one register stage, so the lookup result is ready in time for the first output beat. Backpressure from downstream propagates directly to the input.

Top module: `learning_mac_lookup`

## Requirements
- R1: After reset `mTvalid` is 0, `sTready` is 1 and the table is empty, so the first frame floods.
- R2: Every accepted beat appears on the output, in order, one cycle after acceptance, with `tdata`, `tkeep` and `tlast` unchanged.
- R3: `sTready` equals `!mTvalid || mTready`. While `mTvalid` is high and `mTready` is low, all output signals hold their values.
- R4: The destination address is bytes 0 to 5 of the first beat and the source address is bytes 6 to 11, where byte k sits at `tdata[8k+7:8k]`. The ingress port is a one-hot byte at `tuser[23:16]`.
- R5: On the first beat of each frame, a unicast source address is bound in the table to the frame's ingress port byte.
- R6: When the destination is a unicast address held in the table, `tuser[31:24]` of the first output beat equals the stored port byte.
- R7: When the destination is not in the table, `tuser[31:24]` of the first output beat equals the flood mask (default 8'h55, which selects the even, physical queues).
- R8: An address is a group address when bit 0 of its byte 0 (`tdata[0]` for the destination, `tdata[48]` for the source) is set. A group destination always floods. A group source is never learned and uses no table slot.
- R9: A source address already in the table that arrives on a different port has its stored port replaced, and no new slot is used.
- R10: New addresses take slots in round-robin order. Once all slots are filled, the next new address overwrites the slot that was filled earliest.
- R11: All TUSER bits outside `[31:24]`, and the whole TUSER of every beat after the first, pass through unchanged.
- R12: A frame's lookup sees the table as it stood before that frame's own source address was learned. A frame whose destination equals its own new source address therefore floods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sTdata | input | 256 | Input beat data |
| sTkeep | input | 32 | Input byte enables |
| sTuser | input | 128 | Input side channel, ingress port at [23:16] |
| sTlast | input | 1 | Last beat of the input frame |
| sTvalid | input | 1 | Input beat valid |
| sTready | output | 1 | Input beat accepted when high with sTvalid |
| mTdata | output | 256 | Output beat data |
| mTkeep | output | 32 | Output byte enables |
| mTuser | output | 128 | Output side channel, destination mask at [31:24] on the first beat |
| mTlast | output | 1 | Last beat of the output frame |
| mTvalid | output | 1 | Output beat valid |
| mTready | input | 1 | Downstream ready |

## Verification
The hardest behaviour to bring about from the ports is the interaction between group source addresses and round-robin slot reuse. A wrongly learned group source is invisible until it shifts which slot a later eviction hits. The stimulus fills the table to one slot short of full, sends a frame with a group source, learns one more unicast address and then looks up the oldest entry. If that entry was evicted, the lookup floods instead of hitting. A similar sequence first fills the table and then checks that the earliest entry is the one overwritten. Random multi-beat traffic with random downstream stalls follows, with every output beat compared against a behavioural table model.

// File: rtl/mac_learn_pkg.sv
package mac_learn_pkg;

  // Strobes from the control FSM to the datapath and table
  typedef struct packed {
    logic load;   // capture the input beat into the output stage
    logic first;  // the beat being captured opens a frame
    logic learn;  // write the source binding into the table
  } ctrl_strobes_t;

endpackage

// File: rtl/mac_learn_table.sv
module mac_learn_table #(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned PORT_W  = 8,
  parameter int unsigned MAC_W   = 48
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [MAC_W-1:0]  lookupMac,
  output logic              hit,
  output logic [PORT_W-1:0] hitPort,
  input  logic              learnEn,
  input  logic [MAC_W-1:0]  learnMac,
  input  logic [PORT_W-1:0] learnPort
);

  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] entValid;
  logic [MAC_W-1:0]   entMac  [ENTRIES];
  logic [PORT_W-1:0]  entPort [ENTRIES];
  logic [IDX_W-1:0]   allocPtr;

  logic [ENTRIES-1:0] dstHitVec;
  logic [ENTRIES-1:0] srcHitVec;
  logic [IDX_W-1:0]   srcIdx;
  logic               srcHit;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign dstHitVec[i] = entValid[i] && (entMac[i] == lookupMac);
    assign srcHitVec[i] = entValid[i] && (entMac[i] == learnMac);
  end

  always_comb begin
    hitPort = '0;
    srcIdx  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (dstHitVec[i]) hitPort = hitPort | entPort[i];
      if (srcHitVec[i]) srcIdx  = IDX_W'(i);
    end
  end

  assign hit    = |dstHitVec;
  assign srcHit = |srcHitVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entValid <= '0;
      allocPtr <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        entMac[i]  <= '0;
        entPort[i] <= '0;
      end
    end else if (learnEn) begin
      if (srcHit) begin
        entPort[srcIdx] <= learnPort;
      end else begin
        entValid[allocPtr] <= 1'b1;
        entMac[allocPtr]   <= learnMac;
        entPort[allocPtr]  <= learnPort;
        allocPtr           <= (allocPtr == LAST_IDX) ? '0 : allocPtr + 1'b1;
      end
    end
  end

  // R5
  unique_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(srcHitVec));

  // R9
  update_no_alloc_chk: assert property (@(posedge clk) disable iff (!rstN)
    learnEn && srcHit |=> $stable(allocPtr));

  // R10
  alloc_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    allocPtr <= LAST_IDX);

endmodule

// File: rtl/mac_learn_ctrl.sv
module mac_learn_ctrl
  import mac_learn_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          sValid,
  input  logic          sLast,
  input  logic          srcGroup,
  input  logic          mReady,
  output logic          sReady,
  output logic          mValid,
  output ctrl_strobes_t strb
);

  logic atSof;
  logic accept;

  assign sReady = !mValid || mReady;
  assign accept = sValid && sReady;

  always_comb begin
    strb.load  = accept;
    strb.first = atSof;
    strb.learn = accept && atSof && !srcGroup;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mValid <= 1'b0;
      atSof  <= 1'b1;
    end else begin
      mValid <= accept || (mValid && !mReady);
      if (accept) atSof <= sLast;
    end
  end

  // R2
  accept_emerges_chk: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> mValid);

  // R3
  stall_holds_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    mValid && !mReady |=> mValid);

endmodule

// File: rtl/mac_learn_dp.sv
module mac_learn_dp
  import mac_learn_pkg::*;
#(
  parameter int unsigned DATA_W   = 256,
  parameter int unsigned USER_W   = 128,
  parameter int unsigned PORT_W   = 8,
  parameter int unsigned MAC_W    = 48,
  parameter int unsigned MASK_LSB = 24,
  parameter int unsigned SRC_LSB  = 16,
  parameter logic [PORT_W-1:0] FLOOD = '0
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrl_strobes_t       strb,
  input  logic [DATA_W-1:0]   sData,
  input  logic [DATA_W/8-1:0] sKeep,
  input  logic [USER_W-1:0]   sUser,
  input  logic                sLast,
  input  logic                hit,
  input  logic [PORT_W-1:0]   hitPort,
  input  logic                mValid,
  input  logic                mReady,
  output logic [MAC_W-1:0]    dstMac,
  output logic [MAC_W-1:0]    srcMac,
  output logic [PORT_W-1:0]   srcPort,
  output logic                srcGroup,
  output logic [DATA_W-1:0]   mData,
  output logic [DATA_W/8-1:0] mKeep,
  output logic [USER_W-1:0]   mUser,
  output logic                mLast
);

  localparam int unsigned KEEP_W = DATA_W / 8;

  logic              dstGroup;
  logic [PORT_W-1:0] destMask;

  assign dstMac   = sData[MAC_W-1:0];
  assign srcMac   = sData[2*MAC_W-1:MAC_W];
  assign srcPort  = sUser[SRC_LSB +: PORT_W];
  assign dstGroup = sData[0];
  assign srcGroup = sData[MAC_W];
  assign destMask = (dstGroup || !hit) ? FLOOD : hitPort;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mData <= '0;
      mKeep <= '0;
      mUser <= '0;
      mLast <= 1'b0;
    end else if (strb.load) begin
      mData <= sData;
      mKeep <= sKeep;
      mLast <= sLast;
      mUser <= sUser;
      if (strb.first) mUser[MASK_LSB +: PORT_W] <= destMask;
    end
  end

  // R3
  stall_holds_beat_chk: assert property (@(posedge clk) disable iff (!rstN)
    mValid && !mReady |=> $stable(mData) && $stable(mUser) && $stable(mKeep) && $stable(mLast));

  // R11
  keep_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load && !strb.first |=> mUser == $past(sUser) && KEEP_W > 0);

endmodule

// File: rtl/learning_mac_lookup.sv
module learning_mac_lookup
  import mac_learn_pkg::*;
#(
  parameter int unsigned DATA_W     = 256,
  parameter int unsigned USER_W     = 128,
  parameter int unsigned PORT_W     = 8,
  parameter int unsigned ENTRIES    = 4,
  parameter int unsigned MASK_LSB   = 24,
  parameter int unsigned SRC_LSB    = 16,
  parameter int unsigned FLOOD_MASK = 'h55
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [DATA_W-1:0]   sTdata,
  input  logic [DATA_W/8-1:0] sTkeep,
  input  logic [USER_W-1:0]   sTuser,
  input  logic                sTlast,
  input  logic                sTvalid,
  output logic                sTready,
  output logic [DATA_W-1:0]   mTdata,
  output logic [DATA_W/8-1:0] mTkeep,
  output logic [USER_W-1:0]   mTuser,
  output logic                mTlast,
  output logic                mTvalid,
  input  logic                mTready
);

  localparam int unsigned MAC_W = 48;
  localparam logic [PORT_W-1:0] FLOOD = PORT_W'(FLOOD_MASK);

  ctrl_strobes_t     strb;
  logic [MAC_W-1:0]  dstMac;
  logic [MAC_W-1:0]  srcMac;
  logic [PORT_W-1:0] srcPort;
  logic              srcGroup;
  logic              hit;
  logic [PORT_W-1:0] hitPort;

  mac_learn_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .sValid   (sTvalid),
    .sLast    (sTlast),
    .srcGroup (srcGroup),
    .mReady   (mTready),
    .sReady   (sTready),
    .mValid   (mTvalid),
    .strb     (strb)
  );

  mac_learn_table #(
    .ENTRIES (ENTRIES),
    .PORT_W  (PORT_W),
    .MAC_W   (MAC_W)
  ) table_i (
    .clk       (clk),
    .rstN      (rstN),
    .lookupMac (dstMac),
    .hit       (hit),
    .hitPort   (hitPort),
    .learnEn   (strb.learn),
    .learnMac  (srcMac),
    .learnPort (srcPort)
  );

  mac_learn_dp #(
    .DATA_W   (DATA_W),
    .USER_W   (USER_W),
    .PORT_W   (PORT_W),
    .MAC_W    (MAC_W),
    .MASK_LSB (MASK_LSB),
    .SRC_LSB  (SRC_LSB),
    .FLOOD    (FLOOD)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .sData    (sTdata),
    .sKeep    (sTkeep),
    .sUser    (sTuser),
    .sLast    (sTlast),
    .hit      (hit),
    .hitPort  (hitPort),
    .mValid   (mTvalid),
    .mReady   (mTready),
    .dstMac   (dstMac),
    .srcMac   (srcMac),
    .srcPort  (srcPort),
    .srcGroup (srcGroup),
    .mData    (mTdata),
    .mKeep    (mTkeep),
    .mUser    (mTuser),
    .mLast    (mTlast)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !mTvalid);

endmodule

// File: tb/learning_mac_lookup_tb_top.sv
module learning_mac_lookup_tb_top;

  localparam int DATA_W  = 256;
  localparam int USER_W  = 128;
  localparam int KEEP_W  = DATA_W / 8;
  localparam int ENTRIES = 4;
  localparam logic [7:0] FLOOD = 8'h55;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [DATA_W-1:0] sTdata = '0;
  logic [KEEP_W-1:0] sTkeep = '0;
  logic [USER_W-1:0] sTuser = '0;
  logic              sTlast = 1'b0;
  logic              sTvalid = 1'b0;
  logic              sTready;
  logic [DATA_W-1:0] mTdata;
  logic [KEEP_W-1:0] mTkeep;
  logic [USER_W-1:0] mTuser;
  logic              mTlast;
  logic              mTvalid;
  logic              mTready = 1'b1;

  int  vecCnt = 0;
  int  failCnt = 0;
  bit  done = 0;
  bit  readyMode = 0;

  always #10 clk = ~clk;

  learning_mac_lookup dut_i (
    .clk(clk), .rstN(rstN),
    .sTdata(sTdata), .sTkeep(sTkeep), .sTuser(sTuser), .sTlast(sTlast),
    .sTvalid(sTvalid), .sTready(sTready),
    .mTdata(mTdata), .mTkeep(mTkeep), .mTuser(mTuser), .mTlast(mTlast),
    .mTvalid(mTvalid), .mTready(mTready)
  );

  // Behavioural model of the table
  logic [47:0] tMac [ENTRIES];
  logic [7:0]  tPort [ENTRIES];
  bit          tVal [ENTRIES];
  int          tPtr = 0;

  // Expected output beats
  logic [DATA_W-1:0] qData [$];
  logic [KEEP_W-1:0] qKeep [$];
  logic [USER_W-1:0] qUser [$];
  bit                qLast [$];
  string             qTag [$];

  task automatic modelFirst(input logic [47:0] da, input logic [47:0] sa,
                            input logic [7:0] sp, output logic [7:0] mask,
                            output string tag);
    int found;
    if (da[0]) begin
      mask = FLOOD; tag = "R8 group destination";
    end else begin
      found = -1;
      for (int i = 0; i < ENTRIES; i++) if (tVal[i] && tMac[i] == da) found = i;
      if (found >= 0) begin mask = tPort[found]; tag = "R6 known destination"; end
      else begin mask = FLOOD; tag = "R7 unknown destination"; end
    end
    // learning happens after the lookup (R12)
    if (!sa[0]) begin
      found = -1;
      for (int i = 0; i < ENTRIES; i++) if (tVal[i] && tMac[i] == sa) found = i;
      if (found >= 0) tPort[found] = sp;
      else begin
        tVal[tPtr] = 1; tMac[tPtr] = sa; tPort[tPtr] = sp;
        tPtr = (tPtr + 1) % ENTRIES;
      end
    end
  endtask

  function automatic logic [DATA_W-1:0] rnd256();
    logic [DATA_W-1:0] v;
    for (int i = 0; i < DATA_W / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  // R4: addresses at bytes 0-5 and 6-11, ingress port at tuser[23:16]
  task automatic sendFrame(input logic [47:0] da, input logic [47:0] sa,
                           input logic [7:0] sp, input int nBeats);
    logic [7:0] mask;
    string tag;
    for (int b = 0; b < nBeats; b++) begin
      logic [DATA_W-1:0] d;
      logic [USER_W-1:0] u;
      logic [USER_W-1:0] eu;
      logic [KEEP_W-1:0] k;
      d = rnd256();
      u = {$urandom, $urandom, $urandom, $urandom};
      if (b == 0) begin
        d[47:0]  = da;
        d[95:48] = sa;
        u[23:16] = sp;
      end
      k = (b == nBeats - 1) ? KEEP_W'({$urandom}) | KEEP_W'(1) : '1;
      @(negedge clk);
      sTdata = d; sTuser = u; sTkeep = k;
      sTlast = (b == nBeats - 1); sTvalid = 1'b1;
      #1;
      while (!sTready) begin
        @(negedge clk);
        #1;
      end
      eu = u;
      if (b == 0) begin
        modelFirst(da, sa, sp, mask, tag);
        eu[31:24] = mask;
      end else begin
        tag = "R11 later beat";
      end
      qData.push_back(d); qKeep.push_back(k); qUser.push_back(eu);
      qLast.push_back(b == nBeats - 1); qTag.push_back(tag);
    end
    @(negedge clk);
    sTvalid = 1'b0;
  endtask

  always @(negedge clk) begin
    mTready <= readyMode ? 1'($urandom % 2) : 1'b1;
  end

  // Monitor: compares every clock
  logic [DATA_W-1:0] pData;
  logic [USER_W-1:0] pUser;
  logic [KEEP_W-1:0] pKeep;
  bit                pLast;
  bit                pStall = 0;

  always @(negedge clk) begin
    #2;
    if (rstN && !done) begin
      vecCnt++;
      if (sTready !== (!mTvalid || mTready)) begin
        failCnt++;
        $display("FAIL R3 ready: actual %b expected %b", sTready, !mTvalid || mTready);
      end
      if (pStall) begin
        vecCnt++;
        if (!mTvalid || mTdata !== pData || mTuser !== pUser || mTkeep !== pKeep || mTlast !== pLast) begin
          failCnt++;
          $display("FAIL R3 stall hold: actual valid %b user %h expected valid 1 user %h",
                   mTvalid, mTuser, pUser);
        end
      end
      if (mTvalid && mTready) begin
        vecCnt++;
        if (qData.size() == 0) begin
          failCnt++;
          $display("FAIL R2 extra beat: actual data %h expected none", mTdata);
        end else begin
          if (mTdata !== qData[0] || mTkeep !== qKeep[0] || mTlast !== qLast[0]) begin
            failCnt++;
            $display("FAIL R2 beat: actual %h/%h/%b expected %h/%h/%b",
                     mTdata, mTkeep, mTlast, qData[0], qKeep[0], qLast[0]);
          end
          if (mTuser !== qUser[0]) begin
            failCnt++;
            $display("FAIL %s: actual tuser %h expected %h", qTag[0], mTuser, qUser[0]);
          end
          void'(qData.pop_front()); void'(qKeep.pop_front()); void'(qUser.pop_front());
          void'(qLast.pop_front()); void'(qTag.pop_front());
        end
      end
      pStall = mTvalid && !mTready;
      pData = mTdata; pUser = mTuser; pKeep = mTkeep; pLast = mTlast;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      failCnt++;
      $display("FAIL R2 watchdog: actual run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
      $finish;
    end
  end

  localparam logic [47:0] MAC_Y = 48'h0000_1111_2200;
  localparam logic [47:0] MAC_X = 48'h0000_3333_4402;
  localparam logic [47:0] MAC_Z = 48'h0000_5555_6604;
  localparam logic [47:0] MAC_W = 48'h0000_7777_8806;
  localparam logic [47:0] MAC_V = 48'h0000_9999_aa08;
  localparam logic [47:0] MAC_G = 48'h0000_bbbb_cc01;
  localparam logic [47:0] BCAST = 48'hffff_ffff_ffff;

  initial begin
    logic [47:0] pool [6];
    for (int i = 0; i < ENTRIES; i++) begin tVal[i] = 0; tMac[i] = '0; tPort[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #2;
    // R1: idle after reset
    vecCnt++;
    if (mTvalid !== 1'b0 || sTready !== 1'b1) begin
      failCnt++;
      $display("FAIL R1 reset: actual valid %b ready %b expected 0 1", mTvalid, sTready);
    end
    // R1 R7: empty table floods; R5 learns Y on port 0
    sendFrame(MAC_X, MAC_Y, 8'h01, 2);
    // R6: destination Y now goes to port 0 only
    sendFrame(MAC_Y, MAC_X, 8'h04, 3);
    // R8: broadcast floods
    sendFrame(BCAST, MAC_Y, 8'h01, 1);
    // R12: destination equal to its own new source floods
    sendFrame(MAC_Z, MAC_Z, 8'h02, 1);
    sendFrame(MAC_Z, MAC_X, 8'h04, 1);
    // R9: Y moves to port 4
    readyMode = 1;
    sendFrame(MAC_X, MAC_Y, 8'h10, 2);
    sendFrame(MAC_Y, MAC_X, 8'h04, 1);
    // R8: group source is not learned; W takes the last slot, Y survives
    sendFrame(MAC_X, MAC_G, 8'h20, 1);
    sendFrame(MAC_X, MAC_W, 8'h40, 1);
    sendFrame(MAC_Y, MAC_X, 8'h04, 1);
    sendFrame(MAC_G, MAC_X, 8'h04, 1);
    // R10: V evicts the earliest slot (Y)
    sendFrame(MAC_X, MAC_V, 8'h80, 1);
    sendFrame(MAC_Y, MAC_X, 8'h04, 1);
    sendFrame(MAC_V, MAC_X, 8'h04, 2);
    // Random traffic
    pool[0] = MAC_Y; pool[1] = MAC_X; pool[2] = MAC_Z;
    pool[3] = MAC_W; pool[4] = MAC_V; pool[5] = MAC_G;
    for (int f = 0; f < 80; f++) begin
      readyMode = 1'($urandom % 2);
      sendFrame(pool[$urandom % 6], pool[$urandom % 6], 8'h01 << ($urandom % 8),
                1 + int'($urandom % 4));
    end
    readyMode = 0;
    while (qData.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
      $finish;
    end
  end

endmodule